// File: doc/BRIEF.md
# Bit-Change Detector with Moore and Mealy Outputs

This block watches a serial stream of single bits, one bit per clock, and reports when the newest bit differs from the bit before it. In other words, it flags a 0 followed by a 1, or a 1 followed by a 0. Two independent machines observe the same input and drive two outputs side by side.

A five-state machine drives a registered output. That output depends only on state, so it rises in the cycle after the edge that samples the second bit of a change. A three-state machine drives a second output from its state and the live input bit. It flags a change during the same cycle in which the differing bit is presented.

A synchronous reset puts both machines back to their idle state, so any history of the stream is forgotten. A parameter selects how the five-state machine encodes its state: a dense binary code or a one-hot code. The outputs do not change with the encoding.

Top module: `bit_change_detector`

## Requirements
- R1: While `srst_i` is high at a rising edge, both machines return to idle. `mealy_o` is 0 for as long as `srst_i` is high, whatever the value of `din_i`. `moore_o` is 0 in the cycle after a reset edge.
- R2: The first bit sampled after reset never raises either output, because there is no previous bit to compare it with.
- R3: `mealy_o` is 1 in any cycle where reset is low, at least one bit has been sampled since reset, and `din_i` differs from the most recently sampled bit. In every other cycle it is 0.
- R4: `moore_o` is 1 in the cycle after a rising edge that sampled a bit different from the bit sampled at the edge before it, with no reset at either edge. In every other case it is 0.
- R5: In every cycle after reset, `moore_o` equals the value that `mealy_o` had in the previous cycle.
- R6: A run of equal bits keeps both outputs at 0 after the first bit of the run.
- R7: A strictly alternating stream (0101… or 1010…) keeps `moore_o` at 1 in every cycle from the second sampled bit onward.
- R8: The parameter `MOORE_ENC` selects the state code of the five-state machine: 0 gives a binary code, 1 gives a one-hot code. Both settings give identical output waveforms. Any other value is rejected at elaboration.
- R9: A reset in the middle of a stream discards the previous bit. The first bit after the reset does not flag, even if it differs from the last bit before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| srst_i | input | 1 | Synchronous reset, active high |
| din_i | input | 1 | Serial data bit, sampled every rising edge |
| moore_o | output | 1 | Registered change flag, decoded from state only |
| mealy_o | output | 1 | Same-cycle change flag from state and the live bit |

## Verification
Two events can land in the same cycle: the Mealy output firing on a live bit that differs from the previous one, and a reset or a change of the stream's history. To provoke this, the bench raises reset while presenting a differing bit, and it resets in the middle of alternating streams. In those cycles the same-cycle flag must stay low. The registered flag must then follow the same-cycle flag's previous value, cycle by cycle.

The bench also sweeps every 8-bit stream from reset on two instances, one per state encoding. Both instances are compared against a single arithmetic model that only remembers the previous bit.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

   // Five-state machine: idle, last bit 0/1 without a change, change seen
   typedef enum logic [2:0] {
      MS_IDLE = 3'd0,
      MS_GOT0 = 3'd1,
      MS_GOT1 = 3'd2,
      MS_RISE = 3'd3,
      MS_FALL = 3'd4
   } moore_st_e;

   localparam int unsigned MOORE_NSTATES = 5;
   localparam int unsigned MOORE_BINW    = $clog2(MOORE_NSTATES);

   // Three-state machine: idle, last bit was 0, last bit was 1
   typedef enum logic [1:0] {
      LS_IDLE  = 2'd0,
      LS_LAST0 = 2'd1,
      LS_LAST1 = 2'd2
   } mealy_st_e;

   localparam int unsigned ENC_BINARY = 0;
   localparam int unsigned ENC_ONEHOT = 1;

   // Symbolic successor of the five-state machine
   function automatic moore_st_e moore_succ(input moore_st_e s, input logic b);
      moore_st_e n;
      case (s)
         MS_IDLE: n = b ? MS_GOT1 : MS_GOT0;
         MS_GOT0: n = b ? MS_RISE : MS_GOT0;
         MS_GOT1: n = b ? MS_GOT1 : MS_FALL;
         MS_RISE: n = b ? MS_GOT1 : MS_FALL;
         MS_FALL: n = b ? MS_RISE : MS_GOT0;
         default: n = MS_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/bcd_moore_fsm.sv
module bcd_moore_fsm
   import bcd_pkg::*;
#(
   parameter int unsigned ENC = ENC_BINARY
) (
   input  logic clk_i,
   input  logic srst_i,
   input  logic din_i,
   output logic flag_o
);

   moore_st_e cur_sym;
   moore_st_e nxt_sym;

   assign nxt_sym = moore_succ(cur_sym, din_i);

   generate
      if (ENC == ENC_ONEHOT) begin : g_onehot
         logic [MOORE_NSTATES-1:0] oh_q;
         logic [MOORE_NSTATES-1:0] oh_d;

         always_comb begin
            oh_d = '0;
            oh_d[nxt_sym] = 1'b1;
         end

         always_ff @(posedge clk_i) begin
            if (srst_i) begin
               oh_q <= MOORE_NSTATES'(1) << MS_IDLE;
            end else begin
               oh_q <= oh_d;
            end
         end

         always_comb begin
            cur_sym = MS_IDLE;
            for (int i = 0; i < MOORE_NSTATES; i++) begin
               if (oh_q[i]) cur_sym = moore_st_e'(3'(i));
            end
         end

         assign flag_o = oh_q[MS_RISE] | oh_q[MS_FALL];

         // R8
         onehot_legal_chk: assert property (@(posedge clk_i) disable iff (srst_i)
            $countones(oh_q) == 1);
      end else begin : g_binary
         moore_st_e st_q;

         always_ff @(posedge clk_i) begin
            if (srst_i) begin
               st_q <= MS_IDLE;
            end else begin
               st_q <= nxt_sym;
            end
         end

         assign cur_sym = st_q;
         assign flag_o  = (st_q == MS_RISE) || (st_q == MS_FALL);
      end
   endgenerate

endmodule

// File: rtl/bcd_mealy_fsm.sv
module bcd_mealy_fsm
   import bcd_pkg::*;
(
   input  logic clk_i,
   input  logic srst_i,
   input  logic din_i,
   output logic flag_o
);

   mealy_st_e st_q;
   mealy_st_e st_d;
   logic      raw_flag;

   always_comb begin
      case (st_q)
         LS_LAST0: begin st_d = din_i ? LS_LAST1 : LS_LAST0; raw_flag = din_i;  end
         LS_LAST1: begin st_d = din_i ? LS_LAST1 : LS_LAST0; raw_flag = !din_i; end
         default:  begin st_d = din_i ? LS_LAST1 : LS_LAST0; raw_flag = 1'b0;   end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         st_q <= LS_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   // Gate so the flag is quiet during reset
   assign flag_o = raw_flag & ~srst_i;

   always_comb begin
      // R1
      mealy_rst_quiet_chk: assert (!(srst_i && flag_o));
   end

endmodule

// File: rtl/bit_change_detector.sv
module bit_change_detector
   import bcd_pkg::*;
#(
   parameter int unsigned MOORE_ENC = ENC_BINARY
) (
   input  logic clk_i,
   input  logic srst_i,
   input  logic din_i,
   output logic moore_o,
   output logic mealy_o
);

   generate
      if (MOORE_ENC > ENC_ONEHOT) begin : g_bad_enc
         $error("MOORE_ENC must be 0 (binary) or 1 (one-hot)");
      end
   endgenerate

   bcd_moore_fsm #(.ENC(MOORE_ENC)) moore_i (
      .clk_i  (clk_i),
      .srst_i (srst_i),
      .din_i  (din_i),
      .flag_o (moore_o)
   );

   bcd_mealy_fsm mealy_i (
      .clk_i  (clk_i),
      .srst_i (srst_i),
      .din_i  (din_i),
      .flag_o (mealy_o)
   );

   // R5
   moore_lags_mealy_chk: assert property (@(posedge clk_i) disable iff (srst_i)
      moore_o == $past(mealy_o));

   // R4
   moore_diff_chk: assert property (@(posedge clk_i) disable iff (srst_i)
      (moore_o && !$past(srst_i) && !$past(srst_i, 2)) |-> ($past(din_i) != $past(din_i, 2)));

   // R1
   moore_after_rst_chk: assert property (@(posedge clk_i) disable iff (srst_i)
      $past(srst_i) |-> !moore_o);

endmodule

// File: tb/bit_change_detector_tb_top.sv
module bit_change_detector_tb_top;

   logic clk_i = 1'b0;
   logic srst_i = 1'b1;
   logic din_i = 1'b0;
   logic moore_a, mealy_a, moore_b, mealy_b;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;
   string phase_tag = "";

   // model: previous bit since reset
   logic pv = 1'b0;
   logic pb = 1'b0;

   always #5 clk_i = ~clk_i;

   bit_change_detector #(.MOORE_ENC(0)) dut_i (
      .clk_i(clk_i), .srst_i(srst_i), .din_i(din_i),
      .moore_o(moore_a), .mealy_o(mealy_a));

   bit_change_detector #(.MOORE_ENC(1)) dut_oh_i (
      .clk_i(clk_i), .srst_i(srst_i), .din_i(din_i),
      .moore_o(moore_b), .mealy_o(mealy_b));

   task automatic check(input string tag, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic b, input logic r);
      logic  exp_f;
      logic  me_seen;
      string t;
      @(negedge clk_i);
      din_i  = b;
      srst_i = r;
      #2;
      exp_f = !r && pv && (b != pb);
      if (phase_tag != "")  t = phase_tag;
      else if (r)           t = "R1";
      else if (!pv)         t = "R2";
      else if (b == pb)     t = "R6";
      else                  t = "R3";
      check(t, mealy_a, exp_f);
      check("R8", mealy_b, exp_f);
      me_seen = mealy_a;
      @(posedge clk_i);
      #1;
      if (r) begin pv = 1'b0; end
      else   begin pv = 1'b1; pb = b; end
      if (phase_tag == "" && t == "R3") t = "R4";
      check(t, moore_a, exp_f);
      check("R8", moore_b, exp_f);
      check("R5", moore_a, me_seen);
   endtask

   initial begin
      #100_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state, including reset with a differing bit presented
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);

      // R2 R3 R4 R6: every 8-bit stream from reset
      for (int s = 0; s < 256; s++) begin
         step(1'b0, 1'b1);
         for (int k = 7; k >= 0; k--) begin
            step(s[k], 1'b0);
         end
      end

      // R7: long alternating runs starting with either bit
      for (int first = 0; first < 2; first++) begin
         step(1'b0, 1'b1);
         step(first[0], 1'b0);
         phase_tag = "R7";
         for (int k = 1; k < 20; k++) step(first[0] ^ k[0], 1'b0);
         phase_tag = "";
      end

      // R9: reset mid-stream, then a bit that differs from the last one
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      phase_tag = "R9";
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      phase_tag = "";

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule